// File: doc/BRIEF.md
# Program Memory Read-Protection Controller

This block sits between a programming-mode command port and an on-chip program store of 4 KB. It decides whether the programmer can see the array's contents. A single security flag lives at a dedicated address above the array range. While the flag is clear, the programmer can write, read, compare and blank-check the array freely. Once the flag is set, every programming-mode read of the array returns zeros, and blank check and compare both report failure. The security byte itself can still be read and shows the protection state.

The flag can be armed only after a complete, clean compare pass over the array. Any later array write withdraws that permission. Once armed, the flag holds until a full reset. The core's instruction-fetch path is a separate read port that always sees the true array contents. The array is a plain register model that resets to the erased value 0xFF.

Commands are issued one at a time, with a one-cycle `cmd_valid_i` pulse while `prog_mode_i` is high and `busy_o` is low. Completion is signalled by a one-cycle `done_o` pulse. At that pulse `pass_o`, `err_o` and `rdata_o` hold the result until the next completion.

Top module: `prg_guard`

## Requirements
- R1: After reset, done_o, pass_o, err_o and busy_o are 0 and rdata_o is 0x00. The array holds 0xFF in every byte and protection is off.
- R2: A command is accepted only when cmd_valid_i and prog_mode_i are both high and busy_o is low. A command presented while prog_mode_i is low produces no done_o and does not change the array.
- R3: Command codes are 0 idle, 1 write, 2 read, 3 compare, 4 blank check and 5 arm protection. For any code other than blank check, done_o pulses in the cycle after acceptance. A write to an address below 0x1000 stores wdata_i and reports pass, and a later read of that address returns the byte with pass.
- R4: A read of address 0x7FFF returns the security byte with pass. The byte is 0x00 while protection is off and 0xFF while it is on.
- R5: While protection is on, a read of an array address returns 0x00. A write is ignored and reports err_o = 1 with pass_o = 0.
- R6: A compare reports pass_o = 1 exactly when protection is off and the array byte at addr_i equals wdata_i. While protection is on, every compare reports pass_o = 0.
- R7: Arming succeeds only after compares of addresses 0 to 0xFFF in ascending order have all matched. A run restarts at address 0, and any array write cancels the permission. Arming without permission reports err_o = 1 and leaves the security byte at 0x00.
- R8: Once protection is on, no command clears it; a repeated arm reports pass. Only reset turns protection off.
- R9: Blank check raises busy_o while it scans the whole array. It reports pass_o = 1 only when every byte is 0xFF and protection is off.
- R10: fetch_data_o always returns the true array byte at fetch_addr_i, whatever the protection state and prog_mode_i. It returns 0x00 for addresses at or above 0x1000.
- R11: In programming mode, an address from 0x1000 to 0x7FFE is out of range. A read there returns 0x00 with err_o = 1, and a write there reports err_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_mode_i | input | 1 | Programming mode enable |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| addr_i | input | 15 | Command address |
| wdata_i | input | 8 | Write data or compare value |
| rdata_o | output | 8 | Read result |
| done_o | output | 1 | Completion pulse |
| pass_o | output | 1 | Success flag of last command |
| err_o | output | 1 | Error flag of last command |
| busy_o | output | 1 | Blank-check scan in progress |
| fetch_addr_i | input | 15 | Run-mode fetch address |
| fetch_data_o | output | 8 | Run-mode fetch data |

## Verification
The run-mode fetch port and a programming-mode read can address the same array byte in the same cycle. This matters most while protection is on, because the two paths must then disagree: fetch returns the stored byte and the programming read returns zero. The bench provokes this by presenting a read command and the same fetch address at one clock edge. It samples fetch_data_o before that edge and rdata_o at the completion pulse, then compares each against its own model of the array.

// File: rtl/prg_pkg.sv
package prg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_WR    = 3'd1,
    CMD_RD    = 3'd2,
    CMD_VFY   = 3'd3,
    CMD_BLANK = 3'd4,
    CMD_SEC   = 3'd5
  } cmd_e;
  localparam logic [7:0] ERASED = 8'hFF;
endpackage

// File: rtl/prg_array.sv
module prg_array #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/prg_scan.sv
module prg_scan #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic          blank_o
);
  localparam logic [AW-1:0] LAST = '1;

  logic [AW-1:0] idx_q;
  logic          busy_q, fin_q, acc_q, blank_q;
  logic          is_ff;

  assign is_ff = (rd_data_i == {DW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      acc_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= 1'b1;
      end else if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q  <= 1'b0;
          fin_q   <= 1'b1;
          blank_q <= acc_q & is_ff;
        end else begin
          acc_q <= acc_q & is_ff;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign rd_addr_o = idx_q;
  assign busy_o    = busy_q;
  assign fin_o     = fin_q;
  assign blank_o   = blank_q;

  // R9: a scan result only follows an active scan
  a_r9_fin_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/prg_secure.sv
module prg_secure #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vfy_i,
  input  logic [AW-1:0] vfy_addr_i,
  input  logic          vfy_match_i,
  input  logic          wr_i,
  input  logic          arm_i,
  output logic          verified_o,
  output logic          secured_o
);
  localparam logic [AW-1:0] LAST = '1;

  logic [AW-1:0] vnext_q;
  logic          vrun_ok_q, verified_q, secured_q;
  logic          in_seq;

  assign in_seq = (vfy_addr_i == '0) || (vrun_ok_q && vfy_addr_i == vnext_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vnext_q    <= '0;
      vrun_ok_q  <= 1'b0;
      verified_q <= 1'b0;
      secured_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        verified_q <= 1'b0;
        vrun_ok_q  <= 1'b0;
      end else if (vfy_i) begin
        if (in_seq) begin
          vrun_ok_q <= vfy_match_i;
          vnext_q   <= vfy_addr_i + 1'b1;
          if (vfy_addr_i == LAST && vfy_match_i) verified_q <= 1'b1;
        end else begin
          vrun_ok_q <= 1'b0;
        end
      end
      if (arm_i && verified_q) secured_q <= 1'b1;
    end
  end

  assign verified_o = verified_q;
  assign secured_o  = secured_q;

  a_r8_secure_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secured_q |=> secured_q);
  a_r7_arm_needs_verify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(secured_q) |-> $past(verified_q) && $past(arm_i));
  a_r7_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !verified_q);
endmodule

// File: rtl/prg_guard.sv
module prg_guard
  import prg_pkg::*;
#(
  parameter int              ARR_AW   = 12,
  parameter int              PC_W     = 15,
  parameter int              DW       = 8,
  parameter logic [PC_W-1:0] SEC_ADDR = 15'h7FFF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_mode_i,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_i,
  input  logic [PC_W-1:0] addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            done_o,
  output logic            pass_o,
  output logic            err_o,
  output logic            busy_o,
  input  logic [PC_W-1:0] fetch_addr_i,
  output logic [DW-1:0]   fetch_data_o
);
  localparam int              DEPTH    = 1 << ARR_AW;
  localparam logic [PC_W-1:0] DEPTH_PC = PC_W'(DEPTH);

  logic              accept, in_range, is_sec, f_in_range;
  logic [ARR_AW-1:0] ra_addr, scan_addr;
  logic [DW-1:0]     ra_data, rb_data;
  logic              scan_busy, scan_fin, scan_blank, scan_start;
  logic              arr_we, vfy_match, vfy_go, arm_go;
  logic              verified, secured;
  logic              last_rd_arr_q;
  logic [DW-1:0]     rdata_q;
  logic              done_q, pass_q, err_q;

  assign busy_o     = scan_busy | scan_fin;
  assign accept     = cmd_valid_i & prog_mode_i & ~busy_o;
  assign in_range   = addr_i < DEPTH_PC;
  assign is_sec     = addr_i == SEC_ADDR;
  assign f_in_range = fetch_addr_i < DEPTH_PC;

  assign ra_addr    = scan_busy ? scan_addr : addr_i[ARR_AW-1:0];
  assign arr_we     = accept && cmd_i == CMD_WR && in_range && !secured;
  assign vfy_match  = in_range && !secured && (ra_data == wdata_i);
  assign vfy_go     = accept && cmd_i == CMD_VFY && in_range;
  assign arm_go     = accept && cmd_i == CMD_SEC;
  assign scan_start = accept && cmd_i == CMD_BLANK;

  prg_array #(.AW(ARR_AW), .DW(DW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (arr_we),
    .waddr_i   (addr_i[ARR_AW-1:0]),
    .wdata_i   (wdata_i),
    .ra_addr_i (ra_addr),
    .ra_data_o (ra_data),
    .rb_addr_i (fetch_addr_i[ARR_AW-1:0]),
    .rb_data_o (rb_data)
  );

  prg_scan #(.AW(ARR_AW), .DW(DW)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (scan_start),
    .rd_data_i (ra_data),
    .rd_addr_o (scan_addr),
    .busy_o    (scan_busy),
    .fin_o     (scan_fin),
    .blank_o   (scan_blank)
  );

  prg_secure #(.AW(ARR_AW)) u_secure (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vfy_i       (vfy_go),
    .vfy_addr_i  (addr_i[ARR_AW-1:0]),
    .vfy_match_i (vfy_match),
    .wr_i        (arr_we),
    .arm_i       (arm_go),
    .verified_o  (verified),
    .secured_o   (secured)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q       <= '0;
      done_q        <= 1'b0;
      pass_q        <= 1'b0;
      err_q         <= 1'b0;
      last_rd_arr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (scan_fin) begin
        done_q        <= 1'b1;
        pass_q        <= scan_blank & ~secured;
        err_q         <= 1'b0;
        rdata_q       <= '0;
        last_rd_arr_q <= 1'b0;
      end else if (accept) begin
        done_q        <= 1'b1;
        rdata_q       <= '0;
        last_rd_arr_q <= 1'b0;
        case (cmd_i)
          CMD_NOP: begin pass_q <= 1'b1; err_q <= 1'b0; end
          CMD_WR: begin
            pass_q <= in_range & ~secured;
            err_q  <= ~(in_range & ~secured);
          end
          CMD_RD: begin
            if (is_sec) begin
              rdata_q <= secured ? {DW{1'b1}} : '0;
              pass_q  <= 1'b1;
              err_q   <= 1'b0;
            end else if (in_range) begin
              rdata_q       <= secured ? '0 : ra_data;
              pass_q        <= 1'b1;
              err_q         <= 1'b0;
              last_rd_arr_q <= 1'b1;
            end else begin
              pass_q <= 1'b0;
              err_q  <= 1'b1;
            end
          end
          CMD_VFY: begin pass_q <= vfy_match; err_q <= ~in_range; end
          CMD_BLANK: done_q <= 1'b0;
          CMD_SEC: begin
            pass_q <= verified | secured;
            err_q  <= ~(verified | secured);
          end
          default: begin pass_q <= 1'b0; err_q <= 1'b1; end
        endcase
      end
    end
  end

  assign rdata_o      = rdata_q;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign err_o        = err_q;
  assign fetch_data_o = f_in_range ? rb_data : '0;

  a_r5_secured_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && last_rd_arr_q && secured |-> rdata_q == '0);
  a_r2_no_done_out_of_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!prog_mode_i && !scan_fin) |-> !done_q);
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: tb/sim_prg_guard.sv
`timescale 1ns/1ps
module sim_prg_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_mode = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_o, fetch_data_o;
  logic        done_o, pass_o, err_o, busy_o;
  logic [14:0] fetch_addr = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] r_data;
  logic       r_pass, r_err;
  logic [7:0] exp_mem [4096];

  localparam logic [2:0] C_NOP = 3'd0, C_WR = 3'd1, C_RD = 3'd2, C_VFY = 3'd3,
                         C_BLK = 3'd4, C_SEC = 3'd5;
  localparam logic [14:0] SEC_A = 15'h7FFF;

  always #5 clk = ~clk;

  prg_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .prog_mode_i(prog_mode), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .done_o(done_o),
    .pass_o(pass_o), .err_o(err_o), .busy_o(busy_o), .fetch_addr_i(fetch_addr),
    .fetch_data_o(fetch_data_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) exp_mem[i] = 8'hFF;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [14:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; addr = a; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done_o && n < 10000) begin @(negedge clk); n++; end
    if (!done_o) chk(1'b0, "R3 completion timeout", 0, 1);
    r_data = rdata_o; r_pass = pass_o; r_err = err_o;
  endtask

  task automatic chk_fetch(input logic [14:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    fetch_addr = a;
    #1 chk(fetch_data_o == e, tag, fetch_data_o, e);
  endtask

  task automatic verify_all(output int nfail);
    nfail = 0;
    for (int a = 0; a < 4096; a++) begin
      do_cmd(C_VFY, 15'(a), exp_mem[a]);
      if (!r_pass) nfail++;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk(!done_o && !pass_o && !err_o && !busy_o, "R1 status after reset",
        {done_o, pass_o, err_o, busy_o}, 0);
    chk(rdata_o == 8'h00, "R1 rdata after reset", rdata_o, 0);
    prog_mode = 1'b1;
    do_cmd(C_RD, SEC_A, 8'h00);
    chk(r_data == 8'h00 && r_pass, "R1 security byte off after reset", r_data, 0);
    do_cmd(C_RD, 15'h0123, 8'h00);
    chk(r_data == 8'hFF, "R1 array erased after reset", r_data, 8'hFF);
  endtask

  task automatic t_blank_fresh();
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = C_BLK; addr = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy_o, "R9 busy during scan", busy_o, 1);
    chk(!done_o, "R9 no early done", done_o, 0);
    n = 0;
    while (!done_o && n < 10000) begin @(negedge clk); n++; end
    chk(done_o && pass_o, "R9 blank pass on erased array", pass_o, 1);
    chk(n >= 4000, "R9 scan covers array", n, 4096);
  endtask

  task automatic t_write_read();
    for (int i = 0; i < 16; i++) begin
      logic [11:0] a;
      a = 12'(i * 263 + 5);
      exp_mem[a] = 8'(i * 29 + 8'h11);
      do_cmd(C_WR, {3'b000, a}, exp_mem[a]);
      chk(r_pass && !r_err, "R3 write status", r_pass, 1);
    end
    for (int i = 0; i < 16; i++) begin
      logic [11:0] a;
      a = 12'(i * 263 + 5);
      do_cmd(C_RD, {3'b000, a}, 8'h00);
      chk(r_data == exp_mem[a] && r_pass, "R3 read back", r_data, exp_mem[a]);
    end
    exp_mem[12'hFFF] = 8'h3C;
    do_cmd(C_WR, 15'h0FFF, 8'h3C);
    do_cmd(C_RD, 15'h0FFF, 8'h00);
    chk(r_data == 8'h3C, "R3 top byte", r_data, 8'h3C);
    chk_fetch(15'h0FFF, 8'h3C, "R10 fetch unprotected");
  endtask

  task automatic t_no_prog();
    logic seen;
    seen = 1'b0;
    prog_mode = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = C_WR; addr = 15'h0040; wdata = 8'h99;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) begin if (done_o) seen = 1'b1; @(negedge clk); end
    chk(!seen, "R2 no done outside prog mode", seen, 0);
    chk_fetch(15'h0040, exp_mem[12'h040], "R2 array untouched outside prog mode");
    prog_mode = 1'b1;
  endtask

  task automatic t_range();
    do_cmd(C_RD, 15'h1000, 8'h00);
    chk(r_err && !r_pass && r_data == 8'h00, "R11 out-of-range read", r_err, 1);
    do_cmd(C_WR, 15'h7FFE, 8'h12);
    chk(r_err && !r_pass, "R11 out-of-range write", r_err, 1);
    chk_fetch(15'h1000, 8'h00, "R10 fetch out of range");
  endtask

  task automatic t_early_secure();
    do_cmd(C_SEC, SEC_A, 8'h00);
    chk(r_err && !r_pass, "R7 arm without verify rejected", r_err, 1);
    do_cmd(C_RD, SEC_A, 8'h00);
    chk(r_data == 8'h00, "R4 security byte stays off", r_data, 0);
  endtask

  task automatic t_verify_mismatch();
    do_cmd(C_VFY, 15'h0005, exp_mem[5]);
    chk(r_pass, "R6 compare match", r_pass, 1);
    do_cmd(C_VFY, 15'h0005, ~exp_mem[5]);
    chk(!r_pass, "R6 compare mismatch", r_pass, 0);
  endtask

  task automatic t_blank_dirty();
    do_cmd(C_BLK, '0, 8'h00);
    chk(!r_pass, "R9 blank fails on written array", r_pass, 0);
  endtask

  task automatic t_write_clears();
    int nf;
    verify_all(nf);
    chk(nf == 0, "R6 full compare pass", nf, 0);
    exp_mem[12'h200] = 8'hA5;
    do_cmd(C_WR, 15'h0200, 8'hA5);
    do_cmd(C_SEC, SEC_A, 8'h00);
    chk(r_err, "R7 write cancels arm permission", r_err, 1);
    do_cmd(C_RD, SEC_A, 8'h00);
    chk(r_data == 8'h00, "R7 security still off", r_data, 0);
  endtask

  task automatic t_arm();
    int nf;
    verify_all(nf);
    chk(nf == 0, "R7 full compare pass", nf, 0);
    do_cmd(C_SEC, SEC_A, 8'h00);
    chk(r_pass && !r_err, "R7 arm after verify", r_pass, 1);
    do_cmd(C_RD, SEC_A, 8'h00);
    chk(r_data == 8'hFF && r_pass, "R4 security byte on", r_data, 8'hFF);
  endtask

  task automatic t_secured();
    int nf;
    do_cmd(C_RD, 15'h0005, 8'h00);
    chk(r_data == 8'h00, "R5 protected read zero", r_data, 0);
    // same-cycle fetch and programming read of one byte
    @(negedge clk);
    cmd_valid = 1'b1; cmd = C_RD; addr = 15'h0FFF; fetch_addr = 15'h0FFF;
    #1 chk(fetch_data_o == exp_mem[12'hFFF], "R10 fetch during protected read",
           fetch_data_o, exp_mem[12'hFFF]);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done_o && rdata_o == 8'h00, "R5 concurrent protected read zero", rdata_o, 0);
    do_cmd(C_WR, 15'h0005, 8'h00);
    chk(r_err && !r_pass, "R5 protected write rejected", r_err, 1);
    chk_fetch(15'h0005, exp_mem[5], "R5 protected write ignored");
    do_cmd(C_VFY, 15'h0005, exp_mem[5]);
    chk(!r_pass, "R6 compare fails when protected", r_pass, 0);
    do_cmd(C_BLK, '0, 8'h00);
    chk(!r_pass, "R9 blank fails when protected", r_pass, 0);
    nf = 0;
    for (int a = 0; a < 8; a++) begin
      do_cmd(C_VFY, 15'(a), exp_mem[a]);
      if (r_pass) nf++;
    end
    chk(nf == 0, "R6 no compare passes when protected", nf, 0);
  endtask

  task automatic t_sticky();
    do_cmd(C_SEC, SEC_A, 8'h00);
    chk(r_pass, "R8 repeated arm passes", r_pass, 1);
    do_cmd(C_WR, SEC_A, 8'h00);
    do_cmd(C_NOP, '0, 8'h00);
    do_cmd(3'd7, SEC_A, 8'h00);
    chk(r_err, "R3 unknown code errors", r_err, 1);
    do_cmd(C_RD, SEC_A, 8'h00);
    chk(r_data == 8'hFF, "R8 protection survives commands", r_data, 8'hFF);
    do_reset();
    do_cmd(C_RD, SEC_A, 8'h00);
    chk(r_data == 8'h00, "R8 reset clears protection", r_data, 0);
    do_cmd(C_RD, 15'h0005, 8'h00);
    chk(r_data == 8'hFF, "R8 array readable after reset", r_data, 8'hFF);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    t_reset_state();
    t_blank_fresh();
    t_write_read();
    t_no_prog();
    t_range();
    t_early_secure();
    t_verify_mismatch();
    t_blank_dirty();
    t_write_clears();
    t_arm();
    t_secured();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule